// File: doc/BRIEF.md
# Prescaled Timer Counter

This block is an 8-bit up-counter for a small controller. Its count events come from one of two places. One is an internal tick, which is the system clock divided by a fixed ratio. The other is an external timer pin. The pin is first brought into the clock domain through a two-flop synchroniser. An edge detector then passes either rising or falling transitions.

The chosen event stream goes through a programmable prescaler, which divides by a power of two from 2 to 256. Each prescaler output advances the counter by one. Software reads and writes the counter value through a bus strobe. A bus write also restarts the prescaler.

When the counter wraps from 0xFF to 0x00, a sticky overflow flag is raised. The flag is held by a two-state machine:
- **FLAG_IDLE** moves to **FLAG_RAISED** on the transition named OVERFLOW.
- **FLAG_RAISED** returns to **FLAG_IDLE** on the transition named ACK, which is a clear with no wrap in the same cycle.
- **FLAG_RAISED** stays where it is on HOLD, which is any other case.

The interrupt controller and the register address decode sit outside this block.

Top module: `tmr_counter_top`

## Requirements
- R1: After reset the counter reads 0x00 and the overflow flag reads 0.
- R2: With `src_ext`=0 the count events are internal ticks, one every INT_DIV (default 2) system clocks, and pin activity has no effect. With `src_ext`=1 only pin edges count, and internal ticks have no effect.
- R3: The pin passes two synchroniser flops and then an edge detector. A pin level that is stable before clock edge k produces its counted event at edge k+2, which is when the counter changes.
- R4: `edge_fall`=0 counts rising pin edges. `edge_fall`=1 counts falling pin edges.
- R5: Prescaler code n (`psc_sel` = 0..7) divides the event stream by 2^(n+1). In internal mode the counter therefore advances every INT_DIV·2^(n+1) clocks.
- R6: Each prescaler output adds one to the counter, and 0xFF wraps to 0x00.
- R7: A bus write loads `wr_data` into the counter and restarts both the prescaler and the internal divider. It wins over an increment in the same cycle. After a write in internal mode, the next increment falls INT_DIV·2^(n+1) clocks after the write edge.
- R8: A wrap from 0xFF to 0x00 caused by an increment sets the overflow flag. A bus write never sets it.
- R9: The overflow flag stays set until `flag_clr` is asserted. A clear with no wrap in the same cycle drops the flag to 0.
- R10: If `flag_clr` and a wrap fall in the same cycle, the flag is set after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | External timer pin (asynchronous) |
| src_ext | input | 1 | Source select: 0 internal tick, 1 external pin |
| edge_fall | input | 1 | Pin edge select: 0 rising, 1 falling |
| psc_sel | input | 3 | Prescaler code, divide by 2^(code+1) |
| wr_en | input | 1 | Bus write strobe for the counter |
| wr_data | input | 8 | Bus write data |
| flag_clr | input | 1 | Clears the overflow flag |
| count | output | 8 | Current counter value |
| ovf_flag | output | 1 | Sticky overflow flag |

## Verification
Two pairs of functions can land on the same clock edge.

- **Bus write against increment.** The bench issues a second write on exactly the edge where the prescaler would otherwise fire. It then judges that the written value appears unchanged and that the next increment is pushed a full period later.
- **Clear against wrap.** The bench loads 0xFF and raises `flag_clr` for only the edge on which the wrap happens. The flag must read 1 afterwards, and a later lone clear must drop it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W = 8;
    localparam int PS_W  = 8;
    localparam int SEL_W = $clog2(PS_W);

    typedef enum logic {
        FLAG_IDLE   = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_t;
endpackage

// File: rtl/tmr_source.sv
module tmr_source #(
    parameter int INT_DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_pin,
    input  logic src_ext,
    input  logic edge_fall,
    input  logic restart,
    output logic src_tick
);
    localparam int DIV_W = (INT_DIV > 2) ? $clog2(INT_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(INT_DIV - 1);

    logic [DIV_W-1:0] div_q;
    logic [1:0]       sync_q;
    logic             prev_q;
    logic             int_tick;
    logic             ext_tick;

    // internal clock divider, restarted by a bus write
    always_ff @(posedge clk) begin
        if (!rst_n || restart)   div_q <= '0;
        else if (div_q == DIV_LAST) div_q <= '0;
        else                     div_q <= div_q + 1'b1;
    end
    assign int_tick = (div_q == DIV_LAST);

    // two-flop synchroniser plus previous sample for edge detect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b00;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], ext_pin};
            prev_q <= sync_q[1];
        end
    end

    always_comb begin
        if (edge_fall) ext_tick = prev_q & ~sync_q[1];
        else           ext_tick = sync_q[1] & ~prev_q;
    end

    assign src_tick = src_ext ? ext_tick : int_tick;
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    input  logic             tick_in,
    output logic             tick_out
);
    logic [PS_W-1:0] pre_q;
    logic [PS_W-1:0] tap_mask;

    // mask of sel+1 low ones; code 7 gives all ones
    assign tap_mask = ~({PS_W{1'b1}} << ({1'b0, sel} + 4'd1));

    always_ff @(posedge clk) begin
        if (!rst_n || restart) pre_q <= '0;
        else if (tick_in)      pre_q <= pre_q + 1'b1;
    end

    assign tick_out = tick_in && ((pre_q & tap_mask) == tap_mask);
endmodule

// File: rtl/tmr_counter_top.sv
module tmr_counter_top
    import tmr_pkg::*;
#(
    parameter int INT_DIV = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_pin,
    input  logic             src_ext,
    input  logic             edge_fall,
    input  logic [SEL_W-1:0] psc_sel,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             src_tick;
    logic             inc_pulse;
    logic             wrap;
    logic [CNT_W-1:0] count_q;
    flag_state_t      state_q, state_d;

    tmr_source #(.INT_DIV(INT_DIV)) u_src (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_pin   (ext_pin),
        .src_ext   (src_ext),
        .edge_fall (edge_fall),
        .restart   (wr_en),
        .src_tick  (src_tick)
    );

    tmr_prescaler u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (wr_en),
        .sel      (psc_sel),
        .tick_in  (src_tick),
        .tick_out (inc_pulse)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)         count_q <= '0;
        else if (wr_en)     count_q <= wr_data;
        else if (inc_pulse) count_q <= count_q + 1'b1;
    end

    assign wrap = inc_pulse && !wr_en && (count_q == CNT_MAX);

    // flag state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    // next state: OVERFLOW, ACK, HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:   if (wrap) state_d = FLAG_RAISED;
            FLAG_RAISED: if (flag_clr && !wrap) state_d = FLAG_IDLE;
            default:     state_d = FLAG_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        count    = count_q;
        ovf_flag = (state_q == FLAG_RAISED);
    end
endmodule

// File: rtl/tmr_counter_chk.sv
module tmr_counter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       flag_clr,
    input logic       inc,
    input logic [7:0] count,
    input logic       ovf_flag
);
    a_r7_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> count == $past(wr_data));

    a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (count == $past(count)) || (count == $past(count) + 8'd1));

    a_r8_wrap_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr_en && count == 8'hFF) |=> ovf_flag);

    a_r8_write_no_set: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_flag && !(inc && count == 8'hFF)) |=> !ovf_flag);

    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !flag_clr) |=> ovf_flag);

    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(inc && !wr_en && count == 8'hFF)) |=> !ovf_flag);

    a_r10_clear_loses: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && inc && !wr_en && count == 8'hFF) |=> ovf_flag);
endmodule

bind tmr_counter_top tmr_counter_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .flag_clr (flag_clr),
    .inc      (inc_pulse),
    .count    (count),
    .ovf_flag (ovf_flag)
);

// File: tb/sim_tmr_counter_top.sv
`timescale 1ns/1ps
module sim_tmr_counter_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_pin = 1'b0;
    logic       src_ext = 1'b0;
    logic       edge_fall = 1'b0;
    logic [2:0] psc_sel = 3'd0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'd0;
    logic       flag_clr = 1'b0;
    logic [7:0] count;
    logic       ovf_flag;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tmr_counter_top #(.INT_DIV(2)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .src_ext(src_ext),
        .edge_fall(edge_fall), .psc_sel(psc_sel), .wr_en(wr_en),
        .wr_data(wr_data), .flag_clr(flag_clr), .count(count), .ovf_flag(ovf_flag)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // caller is at a negedge; returns at the negedge after the write edge
    task automatic do_write(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse();
        ext_pin = 1'b1; repeat (4) @(negedge clk);
        ext_pin = 1'b0; repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 count", count, 0);
        check("R1 flag", ovf_flag, 0);
    endtask

    task automatic t_internal_rates();
        src_ext = 0; psc_sel = 3'd0;
        do_write(8'h10);
        wait_edges(3);  check("R5 sel0 before", count, 8'h10);
        wait_edges(1);  check("R6 sel0 step", count, 8'h11);
        wait_edges(8);  check("R6 sel0 two more", count, 8'h13);
        psc_sel = 3'd2;
        do_write(8'h00);
        wait_edges(15); check("R5 sel2 before", count, 0);
        wait_edges(1);  check("R5 sel2 at 16", count, 1);
        psc_sel = 3'd7;
        do_write(8'h00);
        wait_edges(511); check("R5 sel7 before", count, 0);
        wait_edges(1);   check("R5 sel7 at 512", count, 1);
        psc_sel = 3'd0;
    endtask

    task automatic t_source_select();
        src_ext = 0; psc_sel = 3'd0;
        do_write(8'h00);
        for (int i = 0; i < 5; i++) pulse();
        check("R2 internal ignores pin", count, 10);
        src_ext = 1;
        do_write(8'h00);
        wait_edges(100);
        check("R2 external ignores internal", count, 0);
        for (int i = 0; i < 6; i++) pulse();
        wait_edges(4);
        check("R2 external six rises", count, 3);
    endtask

    task automatic t_sync_latency();
        src_ext = 1; edge_fall = 0; psc_sel = 3'd0;
        do_write(8'h00);
        pulse();
        check("R3 one event no count", count, 0);
        ext_pin = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R3 not yet at k+1", count, 0);
        @(posedge clk); @(negedge clk);
        check("R3 counted at k+2", count, 1);
        ext_pin = 1'b0; wait_edges(4);
    endtask

    task automatic t_edge_select();
        src_ext = 1; psc_sel = 3'd0;
        edge_fall = 1;
        ext_pin = 0; wait_edges(4);
        do_write(8'h00);
        ext_pin = 1; wait_edges(4);
        ext_pin = 0; wait_edges(4);
        ext_pin = 1; wait_edges(4);
        check("R4 falling one edge", count, 0);
        edge_fall = 0;
        ext_pin = 0; wait_edges(4);
        do_write(8'h00);
        ext_pin = 1; wait_edges(4);
        ext_pin = 0; wait_edges(4);
        ext_pin = 1; wait_edges(4);
        check("R4 rising two edges", count, 1);
        ext_pin = 0; wait_edges(4);
    endtask

    task automatic t_write_priority();
        src_ext = 0; psc_sel = 3'd0;
        do_write(8'h20);
        wait_edges(3);
        do_write(8'h50);
        check("R7 write wins", count, 8'h50);
        wait_edges(3); check("R7 prescaler restarted", count, 8'h50);
        wait_edges(1); check("R7 next step", count, 8'h51);
    endtask

    task automatic t_overflow();
        src_ext = 1;
        do_write(8'hFF);
        do_write(8'h00);
        check("R8 write no flag", ovf_flag, 0);
        src_ext = 0; psc_sel = 3'd0;
        do_write(8'hFE);
        wait_edges(4); check("R6 reach FF", count, 8'hFF);
        check("R8 no flag yet", ovf_flag, 0);
        wait_edges(4); check("R6 wrap", count, 0);
        check("R8 flag set", ovf_flag, 1);
        wait_edges(20); check("R9 sticky", ovf_flag, 1);
        flag_clr = 1; @(posedge clk); @(negedge clk); flag_clr = 0;
        check("R9 cleared", ovf_flag, 0);
        do_write(8'hFF);
        wait_edges(4); check("R8 flag again", ovf_flag, 1);
        do_write(8'hFF);
        wait_edges(3);
        flag_clr = 1; @(posedge clk); @(negedge clk); flag_clr = 0;
        check("R10 count wrapped", count, 0);
        check("R10 flag kept", ovf_flag, 1);
        flag_clr = 1; @(posedge clk); @(negedge clk); flag_clr = 0;
        check("R9 lone clear", ovf_flag, 0);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_internal_rates();
        t_source_select();
        t_sync_latency();
        t_edge_select();
        t_write_priority();
        t_overflow();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule